// File: doc/BRIEF.md
# Command Trigger Register Bank

This block gives a host a small set of command bits that start operations elsewhere in the datapath. Two word addresses are decoded. The strobe word holds self-clearing trigger bits. Writing a 1 to one of these bits produces a single-clock strobe on the matching output.

The request word holds bits that stay raised once written. Each bit stays high until the datapath returns the acknowledge for that command. While a request is pending the host can read the request word to see which operations are still outstanding. A bit that reads back as 0 means its operation has been acknowledged.

Read data is registered and updates only on a read strobe. The host issues a read or write strobe in a single cycle, together with an address and write data. The datapath consumes the strobe and request outputs and drives one acknowledge line per request bit.

Top module: `cmd_trigger_regs`

## Requirements
- R1: A write to the strobe address (default 0) with bit i of write data at 1 drives pulse_o[i] high for the cycle after the write. In any cycle that does not follow such a write, pulse_o[i] is low.
- R2: A read of the strobe address returns all zeros on rdata in the cycle after rd_en.
- R3: A write to the request address (default 1) with bit i at 1 drives hold_o[i] high from the cycle after the write.
- R4: A raised hold_o[i] stays high while hold_ack_i[i] is low. If hold_ack_i[i] is high and there is no new set of that bit, hold_o[i] is low after the next clock edge.
- R5: A read of the request address returns the request state on rdata[NUM_HOLD-1:0] and zeros above it, in the cycle after rd_en. The state returned is the value held before that cycle's update.
- R6: A 0 in any write data bit leaves the matching strobe or request output unchanged.
- R7: Writing 1 again to a pending request bit keeps hold_o high with no gap.
- R8: If a set write and the acknowledge for the same request bit occur in the same cycle, the bit stays high.
- R9: While the active-low reset rst_n is low, pulse_o, hold_o and rdata are all zero.
- R10: Writes to any other address change no output. Reads from any other address return zero.
- R11: When rd_en is low, rdata keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | ADDR_W | Word address for read and write |
| wdata | input | DATA_W | Host write data |
| rdata | output | DATA_W | Registered read data |
| pulse_o | output | NUM_PULSE | Single-cycle command strobes |
| hold_o | output | NUM_HOLD | Held command requests |
| hold_ack_i | input | NUM_HOLD | Per-request acknowledge from the datapath |

## Verification
Directed sequences separate the two command kinds.

- A strobe write followed by an idle cycle shows that strobes clear themselves.
- A request write followed by idle cycles shows that requests persist.
- A single-bit acknowledge shows that release happens per bit.

Corner patterns cover four cases:
- a zero write over pending requests;
- a rewrite of a pending bit;
- a set colliding with an acknowledge;
- a reset taken while requests are pending.

Each case tells apart priority or masking mistakes that plain traffic would hide. Random traffic then mixes simultaneous reads and writes, unmapped addresses and random acknowledges. This exposes read-before-update ordering and address-decode leaks.

// File: rtl/cmd_trig_pkg.sv
package cmd_trig_pkg;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_PULSE = 2'd1,
        SEL_HOLD  = 2'd2
    } cmd_sel_e;

endpackage

// File: rtl/cmd_addr_decode.sv
module cmd_addr_decode
    import cmd_trig_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int PULSE_ADDR = 0,
    parameter int HOLD_ADDR  = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output cmd_sel_e          sel
);

    localparam logic [ADDR_W-1:0] PULSE_A = ADDR_W'(PULSE_ADDR);
    localparam logic [ADDR_W-1:0] HOLD_A  = ADDR_W'(HOLD_ADDR);

    always_comb begin
        if (addr == PULSE_A) begin
            sel = SEL_PULSE;
        end else if (addr == HOLD_A) begin
            sel = SEL_HOLD;
        end else begin
            sel = SEL_NONE;
        end
    end

endmodule

// File: rtl/cmd_pulse_bank.sv
module cmd_pulse_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fire,
    input  logic [N-1:0] bits,
    output logic [N-1:0] pulse_o
);

    typedef struct packed {
        logic [N-1:0] pulse;
    } pulse_st_t;

    pulse_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = fire ? bits : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;

    for (genvar i = 0; i < N; i++) begin : g_chk
        a_r1_pulse_raise: assert property (@(posedge clk) disable iff (!rst_n)
            (fire && bits[i]) |=> pulse_o[i]);
        a_r1_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
            !(fire && bits[i]) |=> !pulse_o[i]);
    end

endmodule

// File: rtl/cmd_hold_bank.sv
module cmd_hold_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic [N-1:0] set_bits,
    input  logic [N-1:0] ack,
    output logic [N-1:0] hold_o
);

    typedef struct packed {
        logic [N-1:0] req;
    } hold_st_t;

    hold_st_t     st_d, st_q;
    logic [N-1:0] set_w;

    assign set_w = set_en ? set_bits : '0;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (set_w[i]) begin
                st_d.req[i] = 1'b1;
            end else if (ack[i]) begin
                st_d.req[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_o = st_q.req;

    for (genvar i = 0; i < N; i++) begin : g_chk
        a_r3_hold_set: assert property (@(posedge clk) disable iff (!rst_n)
            set_w[i] |=> hold_o[i]);
        a_r4_hold_keep: assert property (@(posedge clk) disable iff (!rst_n)
            (hold_o[i] && !ack[i]) |=> hold_o[i]);
        a_r4_hold_release: assert property (@(posedge clk) disable iff (!rst_n)
            (hold_o[i] && ack[i] && !set_w[i]) |=> !hold_o[i]);
        a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
            (!hold_o[i] && !set_w[i]) |=> !hold_o[i]);
        a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (set_w[i] && ack[i]) |=> hold_o[i]);
    end

endmodule

// File: rtl/cmd_trigger_regs.sv
module cmd_trigger_regs
    import cmd_trig_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 4,
    parameter int NUM_PULSE  = 8,
    parameter int NUM_HOLD   = 8,
    parameter int PULSE_ADDR = 0,
    parameter int HOLD_ADDR  = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic [NUM_PULSE-1:0] pulse_o,
    output logic [NUM_HOLD-1:0]  hold_o,
    input  logic [NUM_HOLD-1:0]  hold_ack_i
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_st_t;

    cmd_sel_e          sel;
    rd_st_t            st_d, st_q;
    logic [NUM_HOLD-1:0] hold_w;
    logic              wdata_unused_par;

    assign wdata_unused_par = ^wdata;

    cmd_addr_decode #(
        .ADDR_W     (ADDR_W),
        .PULSE_ADDR (PULSE_ADDR),
        .HOLD_ADDR  (HOLD_ADDR)
    ) i_dec (
        .addr (addr),
        .sel  (sel)
    );

    cmd_pulse_bank #(
        .N (NUM_PULSE)
    ) i_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (wr_en && (sel == SEL_PULSE)),
        .bits    (wdata[NUM_PULSE-1:0]),
        .pulse_o (pulse_o)
    );

    cmd_hold_bank #(
        .N (NUM_HOLD)
    ) i_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (wr_en && (sel == SEL_HOLD)),
        .set_bits (wdata[NUM_HOLD-1:0]),
        .ack      (hold_ack_i),
        .hold_o   (hold_w)
    );

    assign hold_o = hold_w;

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            if (sel == SEL_HOLD) begin
                st_d.rdata = DATA_W'(hold_w);
            end else begin
                st_d.rdata = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;

    a_r2_strobe_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(PULSE_ADDR)) |=> (rdata == '0));
    a_r5_request_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(HOLD_ADDR)) |=> (rdata == DATA_W'($past(hold_o))));
    a_r10_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr != ADDR_W'(PULSE_ADDR) && addr != ADDR_W'(HOLD_ADDR))
        |=> (rdata == '0));
    a_r11_rdata_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

// File: tb/test_cmd_trigger_regs.sv
module test_cmd_trigger_regs;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 4;
    localparam int NP = 8;
    localparam int NH = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [NP-1:0] pulse_o;
    logic [NH-1:0] hold_o;
    logic [NH-1:0] hold_ack_i = '0;

    int total = 0;
    int bad = 0;

    logic [NP-1:0] m_pulse = '0;
    logic [NH-1:0] m_hold = '0;
    logic [DW-1:0] m_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_trigger_regs #(
        .DATA_W    (DW),
        .ADDR_W    (AW),
        .NUM_PULSE (NP),
        .NUM_HOLD  (NH)
    ) i_cmd_trigger_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .pulse_o    (pulse_o),
        .hold_o     (hold_o),
        .hold_ack_i (hold_ack_i)
    );

    function automatic logic [NP-1:0] nx_pulse(logic w, logic [AW-1:0] a, logic [DW-1:0] d);
        return (w && a == 0) ? d[NP-1:0] : '0;
    endfunction

    function automatic logic [NH-1:0] nx_hold(logic [NH-1:0] cur, logic w, logic [AW-1:0] a,
                                              logic [DW-1:0] d, logic [NH-1:0] k);
        logic [NH-1:0] s;
        s = (w && a == 1) ? d[NH-1:0] : '0;
        return s | (cur & ~k);
    endfunction

    function automatic logic [DW-1:0] nx_rdata(logic [DW-1:0] cur, logic r, logic [AW-1:0] a,
                                               logic [NH-1:0] h);
        if (!r) return cur;
        if (a == 1) return DW'(h);
        return '0;
    endfunction

    task automatic check_all(string tag);
        total++;
        if (pulse_o !== m_pulse) begin
            bad++;
            $display("FAIL %s/R1 pulse_o actual=%h expected=%h", tag, pulse_o, m_pulse);
        end
        total++;
        if (hold_o !== m_hold) begin
            bad++;
            $display("FAIL %s/R4 hold_o actual=%h expected=%h", tag, hold_o, m_hold);
        end
        total++;
        if (rdata !== m_rdata) begin
            bad++;
            $display("FAIL %s/R5 rdata actual=%h expected=%h", tag, rdata, m_rdata);
        end
    endtask

    // Called just after a falling edge: drive, update model, then sample mid-high phase.
    task automatic cycle(string tag, logic w, logic r, logic [AW-1:0] a,
                         logic [DW-1:0] d, logic [NH-1:0] k);
        wr_en = w; rd_en = r; addr = a; wdata = d; hold_ack_i = k;
        m_rdata = nx_rdata(m_rdata, r, a, m_hold);
        m_pulse = nx_pulse(w, a, d);
        m_hold  = nx_hold(m_hold, w, a, d, k);
        @(posedge clk);
        #(CLK_PERIOD/4);
        check_all(tag);
        @(negedge clk);
    endtask

    task automatic idle(string tag);
        cycle(tag, 1'b0, 1'b0, '0, '0, '0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        @(negedge clk);
        check_all("R9_reset");
        rst_n = 1'b1;
        idle("R9_after");

        // R1 strobe then self clear
        cycle("R1_fire", 1'b1, 1'b0, 4'd0, 32'hFFFF_FFA5, '0);
        idle("R1_clear");
        cycle("R1_lowbit", 1'b1, 1'b0, 4'd0, 32'h0000_0001, '0);
        cycle("R1_back2back", 1'b1, 1'b0, 4'd0, 32'h0000_0080, '0);
        idle("R1_clear2");
        // R2 strobe word reads zero
        cycle("R2_read", 1'b0, 1'b1, 4'd0, '0, '0);
        // R3 set requests
        cycle("R3_set", 1'b1, 1'b0, 4'd1, 32'h0000_000F, '0);
        idle("R4_keep");
        idle("R4_keep2");
        // R5 readback while pending
        cycle("R5_read", 1'b0, 1'b1, 4'd1, '0, '0);
        // R4 release one bit
        cycle("R4_ack0", 1'b0, 1'b0, '0, '0, 8'h01);
        cycle("R5_read2", 1'b0, 1'b1, 4'd1, '0, '0);
        // R6 zero write leaves state
        cycle("R6_zero_hold", 1'b1, 1'b0, 4'd1, 32'h0000_0000, '0);
        cycle("R6_zero_pulse", 1'b1, 1'b0, 4'd0, 32'h0000_0000, '0);
        // R7 rewrite while pending
        cycle("R7_rewrite", 1'b1, 1'b0, 4'd1, 32'h0000_0002, '0);
        // R8 set and ack collide on bit 2, ack bit 3 alone
        cycle("R8_collide", 1'b1, 1'b0, 4'd1, 32'h0000_0004, 8'h0C);
        // R5 read and write same cycle returns prior state
        cycle("R5_rd_wr", 1'b1, 1'b1, 4'd1, 32'h0000_00F0, '0);
        cycle("R5_read3", 1'b0, 1'b1, 4'd1, '0, '0);
        // R10 unmapped address
        cycle("R10_wr", 1'b1, 1'b0, 4'd5, 32'hFFFF_FFFF, '0);
        cycle("R10_rd", 1'b0, 1'b1, 4'd5, '0, '0);
        cycle("R5_read4", 1'b0, 1'b1, 4'd1, '0, '0);
        // R11 rdata holds without read
        cycle("R11_hold", 1'b1, 1'b0, 4'd1, 32'h0000_0001, 8'hF0);
        idle("R11_hold2");
        // R9 reset mid-run with requests pending
        cycle("R9_pre", 1'b1, 1'b1, 4'd1, 32'h0000_00FF, '0);
        rst_n = 1'b0;
        m_pulse = '0; m_hold = '0; m_rdata = '0;
        #1;
        check_all("R9_midrun");
        @(negedge clk);
        rst_n = 1'b1;
        idle("R9_release");

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            logic          w, r;
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            logic [NH-1:0] k;
            w = ($urandom % 3) != 0;
            r = ($urandom % 2) != 0;
            a = (($urandom % 4) == 0) ? AW'($urandom) : AW'($urandom % 2);
            d = $urandom;
            k = (($urandom % 2) == 0) ? NH'($urandom) : '0;
            cycle("RND", w, r, a, d, k);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule